// File: doc/BRIEF.md
# PHY Link-Status Poll Scheduler

This block keeps a per-port copy of PHY link state current without any processor work. While its global enable is high it sweeps the ports in ascending order. For each enabled port it looks up the 5-bit PHY address, the management bus the PHY sits on, and whether that bus is polled with Clause 22 or Clause 45 frames. It then issues one or more register reads to that bus's MDIO access engine, one read in flight at a time. When every read for a port completes cleanly, the block updates the port's link, speed and duplex outputs together.

The registers to poll come from 32-bit descriptors that pack a bit index, an MMD device and a register number. A bus can be switched to a single-read mode, in which one resolution register supplies all three fields. A port whose read reports an error keeps its previous status and raises an error flag. After each full sweep the scheduler waits a programmable number of idle cycles before it starts the next. Software must hold the global enable low while it programs PHYs by other means.

Top module: `link_poll_sched`

## Requirements
- R1: While reset is asserted and after its release, all status outputs and error flags are 0 and no request is raised until poll_en is 1.
- R2: A port's PHY address is the 5-bit field at bit (port mod 6)*5 of 32-bit word port/6 of addr_map, and it is driven on req_phy for every read of that port.
- R3: A port's bus is the 2-bit field at bit (port mod 16)*2 of word port/16 of bus_map. Only that bus's req_valid bit is raised, at most one bit is high at a time, and a new read is issued only after the previous response.
- R4: Bit 16+bus of glb_ctrl set means Clause 45: req_c45=1, req_dev and req_reg come from descriptor bits [20:16] and [15:0]. When the bit is clear: req_c45=0, req_dev=0, req_reg = descriptor bits [4:0] zero-extended.
- R5: In standard mode a port takes three reads in this order: link_desc, speed_desc, dup_desc. With b = descriptor bits [24:21] mod 16, link = data[b] of the first read, speed = {data[b+1], data[b]} of the second, and duplex = data[b] of the third.
- R6: Bit 20+bus of glb_ctrl set selects single-read mode on that bus. res_desc is read once, and link = data[b], duplex = data[b+1], speed = {data[b+3], data[b+2]}, with all indices taken mod 16.
- R7: Ports are visited in ascending order. A port whose port_en bit is 0 is never read and its outputs stay unchanged.
- R8: No request is raised while poll_en is 0. Dropping poll_en mid-sweep abandons the sweep, and the next sweep starts again at port 0.
- R9: A port's status changes only on the cycle its last read returns without error, and that cycle also clears its error flag. If any read of the port returns rsp_err, the port's status holds, its flag is set, and its remaining reads for the sweep are skipped.
- R10: After the last read of a sweep, at least idle_cycles+2 clock cycles pass before the first request of the next sweep.
- R11: A raised request keeps its bus, address, device, register and clause fields unchanged until req_ready is seen, unless poll_en drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_en | input | 1 | Global polling enable |
| port_en | input | NPORT | Per-port poll enable |
| addr_map | input | 32*ceil(NPORT/6) | Packed PHY address map |
| bus_map | input | 32*ceil(NPORT/16) | Packed bus selector map |
| glb_ctrl | input | 32 | Per-bus clause bits [19:16], single-read mode bits [23:20] |
| link_desc | input | 32 | Descriptor for the link read |
| speed_desc | input | 32 | Descriptor for the speed read |
| dup_desc | input | 32 | Descriptor for the duplex read |
| res_desc | input | 32 | Descriptor for the resolution read |
| idle_cycles | input | IDLE_W | Idle interval between sweeps |
| req_valid | output | 4 | Read request, one bit per bus |
| req_ready | input | 4 | Request accepted by the bus engine |
| req_c45 | output | 1 | Request uses Clause 45 |
| req_phy | output | 5 | PHY address |
| req_dev | output | 5 | MMD device (0 for Clause 22) |
| req_reg | output | 16 | Register number |
| rsp_valid | input | 4 | Read response, one bit per bus |
| rsp_err | input | 4 | Response carries an error |
| rsp_data | input | 64 | Response data, 16 bits per bus |
| link_up | output | NPORT | Per-port link state |
| speed | output | 2*NPORT | Per-port speed code |
| full_dup | output | NPORT | Per-port duplex |
| poll_err | output | NPORT | Per-port last-poll error flag |

## Verification
The hardest case to reach from the ports is an error that arrives in the middle of a port's multi-read sequence. The remaining reads must be skipped, the next port must follow, and the stale status must survive untouched. The bench arms a one-shot error on the second read of a chosen standard-mode port and predicts the shortened request stream. The other hard case is dropping the enable while a sweep is partly done. The bench clears its expected stream and checks that the next sweep restarts at the first enabled port.

// File: rtl/lps_pkg.sv
package lps_pkg;
  localparam int BSEL_W = 2;
  localparam int NBUS   = 1 << BSEL_W;
  localparam int DATA_W = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_PICK, ST_REQ, ST_RSP} st_e;

  localparam logic [1:0] STEP_LINK = 2'd0;
  localparam logic [1:0] STEP_SPD  = 2'd1;
  localparam logic [1:0] STEP_DUP  = 2'd2;
endpackage

// File: rtl/lps_port_map.sv
module lps_port_map
  import lps_pkg::*;
#(
  parameter int PIDX_W = 3,
  parameter int AMAP_W = 64,
  parameter int BMAP_W = 32
) (
  input  logic [PIDX_W-1:0] port_idx,
  input  logic [AMAP_W-1:0] addr_map,
  input  logic [BMAP_W-1:0] bus_map,
  input  logic [NBUS-1:0]   c45_en,
  input  logic [NBUS-1:0]   res_en,
  output logic [4:0]        phy_addr,
  output logic [BSEL_W-1:0] bus_sel,
  output logic              c45,
  output logic              res_mode
);
  int unsigned apos, bpos;

  always_comb begin
    apos     = (32'(port_idx) / 6) * 32 + (32'(port_idx) % 6) * 5;
    bpos     = (32'(port_idx) / 16) * 32 + (32'(port_idx) % 16) * 2;
    phy_addr = addr_map[apos +: 5];
    bus_sel  = bus_map[bpos +: BSEL_W];
    c45      = c45_en[bus_sel];
    res_mode = res_en[bus_sel];
  end
endmodule

// File: rtl/lps_desc_sel.sv
module lps_desc_sel
  import lps_pkg::*;
(
  input  logic [1:0]  step,
  input  logic        c45,
  input  logic        res_mode,
  input  logic [31:0] link_d,
  input  logic [31:0] speed_d,
  input  logic [31:0] dup_d,
  input  logic [31:0] res_d,
  output logic [4:0]  dev,
  output logic [15:0] regnum,
  output logic [3:0]  bidx,
  output logic        last
);
  logic [31:0] sel;
  logic        unused_bits;

  always_comb begin
    if (res_mode)               sel = res_d;
    else if (step == STEP_LINK) sel = link_d;
    else if (step == STEP_SPD)  sel = speed_d;
    else                        sel = dup_d;
    last   = res_mode | (step == STEP_DUP);
    dev    = c45 ? sel[20:16] : 5'd0;
    regnum = c45 ? sel[15:0] : {11'd0, sel[4:0]};
    bidx   = sel[24:21];
  end

  assign unused_bits = ^sel[31:25];
endmodule

// File: rtl/lps_status_bank.sv
module lps_status_bank #(
  parameter int NPORT  = 8,
  parameter int PIDX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic              err_set,
  input  logic [PIDX_W-1:0] idx,
  input  logic              new_link,
  input  logic [1:0]        new_spd,
  input  logic              new_dup,
  output logic [NPORT-1:0]  link_up,
  output logic [2*NPORT-1:0] speed,
  output logic [NPORT-1:0]  full_dup,
  output logic [NPORT-1:0]  poll_err
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic       hit;
    logic       lk_q, dp_q, er_q;
    logic [1:0] sp_q;

    assign hit = (idx == PIDX_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lk_q <= 1'b0;
        sp_q <= 2'd0;
        dp_q <= 1'b0;
      end else if (commit && hit) begin
        lk_q <= new_link;
        sp_q <= new_spd;
        dp_q <= new_dup;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                er_q <= 1'b0;
      else if (err_set && hit)   er_q <= 1'b1;
      else if (commit && hit)    er_q <= 1'b0;
    end

    assign link_up[p]        = lk_q;
    assign speed[2*p +: 2]   = sp_q;
    assign full_dup[p]       = dp_q;
    assign poll_err[p]       = er_q;
  end
endmodule

// File: rtl/link_poll_sched.sv
module link_poll_sched
  import lps_pkg::*;
#(
  parameter  int NPORT  = 8,
  parameter  int IDLE_W = 16,
  localparam int PIDX_W = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int AMAP_W = ((NPORT + 5) / 6) * 32,
  localparam int BMAP_W = ((NPORT + 15) / 16) * 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 poll_en,
  input  logic [NPORT-1:0]     port_en,
  input  logic [AMAP_W-1:0]    addr_map,
  input  logic [BMAP_W-1:0]    bus_map,
  input  logic [31:0]          glb_ctrl,
  input  logic [31:0]          link_desc,
  input  logic [31:0]          speed_desc,
  input  logic [31:0]          dup_desc,
  input  logic [31:0]          res_desc,
  input  logic [IDLE_W-1:0]    idle_cycles,
  output logic [NBUS-1:0]      req_valid,
  input  logic [NBUS-1:0]      req_ready,
  output logic                 req_c45,
  output logic [4:0]           req_phy,
  output logic [4:0]           req_dev,
  output logic [15:0]          req_reg,
  input  logic [NBUS-1:0]      rsp_valid,
  input  logic [NBUS-1:0]      rsp_err,
  input  logic [NBUS*DATA_W-1:0] rsp_data,
  output logic [NPORT-1:0]     link_up,
  output logic [2*NPORT-1:0]   speed,
  output logic [NPORT-1:0]     full_dup,
  output logic [NPORT-1:0]     poll_err
);
  localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NPORT - 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  st_e               st_q, st_d;
  logic [PIDX_W-1:0] port_q, port_d;
  logic [1:0]        step_q, step_d;
  logic [IDLE_W-1:0] cnt_q, cnt_d;
  logic              tl_q, tl_d;
  logic [1:0]        ts_q, ts_d;

  logic [4:0]        phy_addr;
  logic [BSEL_W-1:0] bus_sel;
  logic              c45, res_mode, last;
  logic [4:0]        dev;
  logic [15:0]       regnum;
  logic [3:0]        bidx, b1, b2, b3;
  logic [DATA_W-1:0] rd;
  logic              hit, commit, err_set;
  logic              new_link, new_dup;
  logic [1:0]        new_spd;
  logic              unused_glb;

  assign unused_glb = ^{glb_ctrl[31:24], glb_ctrl[15:0]};

  lps_port_map #(.PIDX_W(PIDX_W), .AMAP_W(AMAP_W), .BMAP_W(BMAP_W)) u_map (
    .port_idx(port_q), .addr_map(addr_map), .bus_map(bus_map),
    .c45_en(glb_ctrl[16 +: NBUS]), .res_en(glb_ctrl[20 +: NBUS]),
    .phy_addr(phy_addr), .bus_sel(bus_sel), .c45(c45), .res_mode(res_mode)
  );

  lps_desc_sel u_desc (
    .step(step_q), .c45(c45), .res_mode(res_mode),
    .link_d(link_desc), .speed_d(speed_desc), .dup_d(dup_desc), .res_d(res_desc),
    .dev(dev), .regnum(regnum), .bidx(bidx), .last(last)
  );

  assign rd  = rsp_data[{bus_sel, 4'd0} +: DATA_W];
  assign hit = rsp_valid[bus_sel];
  assign b1  = bidx + 4'd1;
  assign b2  = bidx + 4'd2;
  assign b3  = bidx + 4'd3;

  always_comb begin
    new_link = res_mode ? rd[bidx] : tl_q;
    new_dup  = res_mode ? rd[b1]   : rd[bidx];
    new_spd  = res_mode ? {rd[b3], rd[b2]} : ts_q;
  end

  // next-state logic
  always_comb begin
    st_d    = st_q;
    port_d  = port_q;
    step_d  = step_q;
    cnt_d   = cnt_q;
    tl_d    = tl_q;
    ts_d    = ts_q;
    commit  = 1'b0;
    err_set = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (!poll_en) cnt_d = '0;
        else if (cnt_q == idle_cycles) begin
          st_d   = ST_PICK;
          port_d = '0;
          cnt_d  = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ST_PICK: begin
        if (!poll_en)                 st_d = ST_IDLE;
        else if (port_en[port_q]) begin
          st_d   = ST_REQ;
          step_d = STEP_LINK;
        end else if (port_q == LAST_PORT) st_d = ST_IDLE;
        else                          port_d = port_q + 1'b1;
      end
      ST_REQ: begin
        if (!poll_en)                 st_d = ST_IDLE;
        else if (req_ready[bus_sel])  st_d = ST_RSP;
      end
      ST_RSP: begin
        if (hit) begin
          if (rsp_err[bus_sel] || last) begin
            err_set = rsp_err[bus_sel];
            commit  = !rsp_err[bus_sel];
            if (port_q == LAST_PORT) st_d = ST_IDLE;
            else begin
              port_d = port_q + 1'b1;
              st_d   = ST_PICK;
            end
          end else begin
            if (step_q == STEP_LINK) tl_d = rd[bidx];
            else                     ts_d = {rd[b1], rd[bidx]};
            step_d = step_q + 1'b1;
            st_d   = ST_REQ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      port_q <= '0;
      step_q <= STEP_LINK;
      cnt_q  <= '0;
      tl_q   <= 1'b0;
      ts_q   <= 2'd0;
    end else begin
      st_q   <= st_d;
      port_q <= port_d;
      step_q <= step_d;
      cnt_q  <= cnt_d;
      tl_q   <= tl_d;
      ts_q   <= ts_d;
    end
  end

  assign req_valid = (st_q == ST_REQ && poll_en) ? (NBUS'(1) << bus_sel) : '0;
  assign req_c45   = c45;
  assign req_phy   = phy_addr;
  assign req_dev   = dev;
  assign req_reg   = regnum;

  lps_status_bank #(.NPORT(NPORT), .PIDX_W(PIDX_W)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .commit(commit), .err_set(err_set), .idx(port_q),
    .new_link(new_link), .new_spd(new_spd), .new_dup(new_dup),
    .link_up(link_up), .speed(speed), .full_dup(full_dup), .poll_err(poll_err)
  );
endmodule

// File: rtl/lps_checker.sv
module lps_checker #(
  parameter int NPORT = 8,
  parameter int NBUS  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               poll_en,
  input logic [NBUS-1:0]    req_valid,
  input logic [NBUS-1:0]    req_ready,
  input logic               req_c45,
  input logic [4:0]         req_phy,
  input logic [4:0]         req_dev,
  input logic [15:0]        req_reg,
  input logic [NBUS-1:0]    rsp_valid,
  input logic [NPORT-1:0]   link_up,
  input logic [2*NPORT-1:0] speed,
  input logic [NPORT-1:0]   full_dup,
  input logic [NPORT-1:0]   poll_err
);
  a_r3_one_bus: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid));

  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_en |-> (req_valid == '0));

  a_r4_c22_fields: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid != '0) && !req_c45) |-> (req_dev == 5'd0 && req_reg[15:5] == 11'd0));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_valid != '0) && ((req_valid & req_ready) == '0)) |=>
      (!poll_en || ($stable(req_valid) && $stable(req_phy) && $stable(req_dev)
                    && $stable(req_reg) && $stable(req_c45))));

  a_r9_update_needs_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({link_up, speed, full_dup}) |-> $past(rsp_valid != '0));

  a_r9_err_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((poll_err & ~$past(poll_err)) != '0) |-> $stable({link_up, speed, full_dup}));
endmodule

bind link_poll_sched lps_checker #(.NPORT(NPORT), .NBUS(lps_pkg::NBUS)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll_en(poll_en), .req_valid(req_valid),
  .req_ready(req_ready), .req_c45(req_c45), .req_phy(req_phy), .req_dev(req_dev),
  .req_reg(req_reg), .rsp_valid(rsp_valid), .link_up(link_up), .speed(speed),
  .full_dup(full_dup), .poll_err(poll_err)
);

// File: tb/tb_link_poll_sched.sv
module tb_link_poll_sched;
  localparam int NP = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_v = 1'b0;
  logic [7:0]  pen_v;
  logic [63:0] addr_v;
  logic [31:0] bus_v, glb_v, dl_v, ds_v, dd_v, dr_v;
  logic [15:0] idle_v;
  logic [3:0]  rdy_v = '0, rv_v = '0, re_v = '0;
  logic [63:0] rdat_v = '0;

  logic [3:0]  req_valid;
  logic        req_c45;
  logic [4:0]  req_phy, req_dev;
  logic [15:0] req_reg;
  logic [7:0]  link_up, full_dup, poll_err;
  logic [15:0] speed;

  always #2 clk = ~clk;

  link_poll_sched #(.NPORT(NP), .IDLE_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .poll_en(en_v), .port_en(pen_v), .addr_map(addr_v),
    .bus_map(bus_v), .glb_ctrl(glb_v), .link_desc(dl_v), .speed_desc(ds_v),
    .dup_desc(dd_v), .res_desc(dr_v), .idle_cycles(idle_v), .req_valid(req_valid),
    .req_ready(rdy_v), .req_c45(req_c45), .req_phy(req_phy), .req_dev(req_dev),
    .req_reg(req_reg), .rsp_valid(rv_v), .rsp_err(re_v), .rsp_data(rdat_v),
    .link_up(link_up), .speed(speed), .full_dup(full_dup), .poll_err(poll_err)
  );

  typedef struct {
    int port; int step; int bus; int phy; bit c45; int dev; int rg; bit last; bit res; int b;
  } rq_t;

  rq_t q[$];
  rq_t pend;
  int  total = 0, bad = 0, cyc = 0, sweeps = 0, epoch = 0, last_rsp_cyc = 0;
  bit  gap_skip = 1, pend_on = 0, acc_prev = 0, rsp_live = 0, h_on = 0;
  int  pend_cnt = 0;
  int  inj_port = -1, inj_step = -1;
  bit  inj_arm = 0;
  logic [7:0]  m_link = '0, m_dup = '0, m_err = '0;
  logic [15:0] m_spd = '0;
  logic        t_link = 0;
  logic [1:0]  t_spd = 0;
  logic [15:0] live_data;
  logic        live_err;
  logic [3:0]  h_valid;
  logic [4:0]  h_phy, h_dev;
  logic [15:0] h_reg;
  logic        h_c45;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  function automatic logic [15:0] phy_data(int bus, int phy, int dev, int rg);
    int x;
    x = phy * 37 + rg * 13 + dev * 7 + bus * 3 + epoch * 11 + 5;
    return 16'(x ^ (x << 5) ^ (x >> 2) ^ 'hA5C3);
  endfunction

  function automatic int bus_of(int p);
    return int'(bus_v[(p % 16) * 2 +: 2]);
  endfunction

  function automatic int phy_of(int p);
    return int'(addr_v[(p / 6) * 32 + (p % 6) * 5 +: 5]);
  endfunction

  function automatic rq_t mk(int p, int s, logic [31:0] d, bit last, bit res);
    rq_t r;
    r.port = p; r.step = s; r.bus = bus_of(p); r.phy = phy_of(p);
    r.c45 = glb_v[16 + r.bus];
    r.dev = r.c45 ? int'(d[20:16]) : 0;
    r.rg  = r.c45 ? int'(d[15:0]) : int'(d[4:0]);
    r.last = last; r.res = res; r.b = int'(d[24:21]);
    return r;
  endfunction

  task automatic build_sweep();
    for (int p = 0; p < NP; p++) begin
      if (pen_v[p]) begin
        if (glb_v[20 + bus_of(p)]) q.push_back(mk(p, 0, dr_v, 1, 1));
        else begin
          q.push_back(mk(p, 0, dl_v, 0, 0));
          q.push_back(mk(p, 1, ds_v, 0, 0));
          q.push_back(mk(p, 2, dd_v, 1, 0));
        end
      end
    end
  endtask

  task automatic apply_rsp(input rq_t r, input logic [15:0] d, input logic e);
    int b = r.b;
    if (e) begin
      m_err[r.port] = 1'b1;
      while (q.size() > 0 && q[0].port == r.port) void'(q.pop_front());
    end else if (r.res) begin
      m_link[r.port] = d[b];
      m_dup[r.port]  = d[(b + 1) % 16];
      m_spd[2*r.port +: 2] = {d[(b + 3) % 16], d[(b + 2) % 16]};
      m_err[r.port] = 1'b0;
    end else if (r.step == 0) t_link = d[b];
    else if (r.step == 1) t_spd = {d[(b + 1) % 16], d[b]};
    else begin
      m_link[r.port] = t_link;
      m_spd[2*r.port +: 2] = t_spd;
      m_dup[r.port] = d[b];
      m_err[r.port] = 1'b0;
    end
    if (q.size() == 0) begin
      sweeps++;
      last_rsp_cyc = cyc;
    end
  endtask

  task automatic set_port(int p, int a, int b);
    addr_v[(p / 6) * 32 + (p % 6) * 5 +: 5] = 5'(a);
    bus_v[(p % 16) * 2 +: 2] = 2'(b);
  endtask

  // bus engine emulation and per-clock model comparison
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000) begin
        chk(0, "watchdog expired", cyc, 150000);
        finish_run();
      end
      if (acc_prev) begin
        pend_on = 1; pend_cnt = cyc % 2; acc_prev = 0;
      end
      if (rsp_live) begin
        apply_rsp(pend, live_data, live_err);
        rsp_live = 0;
      end
      chk(link_up == m_link && speed == m_spd && full_dup == m_dup, "R5 R6 R7 status",
          {link_up, speed, full_dup}, {m_link, m_spd, m_dup});
      chk(poll_err == m_err, "R9 error flags", poll_err, m_err);
      rv_v = '0; re_v = '0;
      if (pend_on) begin
        if (pend_cnt == 0) begin
          live_data = phy_data(pend.bus, pend.phy, pend.dev, pend.rg);
          live_err  = inj_arm && pend.port == inj_port && pend.step == inj_step;
          if (live_err) inj_arm = 0;
          rdat_v[pend.bus * 16 +: 16] = live_data;
          rv_v[pend.bus] = 1'b1;
          re_v[pend.bus] = live_err;
          rsp_live = 1; pend_on = 0;
        end else pend_cnt--;
      end
      rdy_v = (cyc % 3 != 0) ? 4'hF : 4'h0;
      #1;
      if (!en_v) chk(req_valid == '0, "R8 no request while disabled", req_valid, 0);
      if (h_on && en_v)
        chk(req_valid == h_valid && req_phy == h_phy && req_dev == h_dev &&
            req_reg == h_reg && req_c45 == h_c45, "R11 request held",
            {req_valid, req_phy, req_reg}, {h_valid, h_phy, h_reg});
      h_on = 0;
      if (req_valid != '0) begin
        if ((req_valid & rdy_v) != '0) begin
          if (q.size() == 0) begin
            if (!gap_skip)
              chk(cyc - last_rsp_cyc >= int'(idle_v) + 2, "R10 idle gap",
                  cyc - last_rsp_cyc, int'(idle_v) + 2);
            gap_skip = 0;
            build_sweep();
          end
          if (q.size() == 0) chk(0, "R7 unexpected request", req_phy, 0);
          else begin
            pend = q.pop_front();
            chk(req_valid == 4'(1 << pend.bus), "R3 bus select", req_valid, 1 << pend.bus);
            chk(int'(req_phy) == pend.phy, "R2 phy address", req_phy, pend.phy);
            chk(req_c45 == pend.c45 && int'(req_dev) == pend.dev && int'(req_reg) == pend.rg,
                "R4 clause fields", {req_c45, req_dev, req_reg}, {pend.c45, 5'(pend.dev), 16'(pend.rg)});
            chk(!pend_on && !rsp_live, "R3 single outstanding", pend_on, 0);
            acc_prev = 1;
          end
        end else begin
          h_on = 1; h_valid = req_valid; h_phy = req_phy; h_dev = req_dev;
          h_reg = req_reg; h_c45 = req_c45;
        end
      end
    end
  end

  initial begin
    // configuration A: mixed clauses, one bus in single-read mode, two ports off
    pen_v = 8'b1011_0111;
    addr_v = '0; bus_v = '0;
    for (int p = 0; p < NP; p++) set_port(p, 3 * p + 1, (p * 3) % 4);
    glb_v  = 32'h0000_0000 | (32'h1 << 17) | (32'h1 << 19) | (32'h1 << 22);
    dl_v   = (32'd2 << 21) | (32'd1 << 16) | 32'h0001;
    ds_v   = (32'd6 << 21) | (32'd30 << 16) | 32'hA43A;
    dd_v   = (32'd8 << 21) | (32'd30 << 16) | 32'hA43C;
    dr_v   = (32'd13 << 21) | (32'd31 << 16) | 32'hA434;
    idle_v = 16'd20;
    repeat (4) @(negedge clk);
    chk(link_up == 0 && speed == 0 && full_dup == 0 && poll_err == 0 && req_valid == 0,
        "R1 reset state", {link_up, poll_err, req_valid}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(req_valid == 0 && link_up == 0, "R1 idle after release", req_valid, 0);
    en_v = 1'b1;
    wait (sweeps >= 2);
    epoch = 1;
    wait (sweeps >= 3);
    inj_port = 4; inj_step = 1; inj_arm = 1;
    wait (sweeps >= 4);
    @(negedge clk); #1;
    chk(poll_err[4] == 1'b1, "R9 error flag raised", poll_err, 8'h10);
    epoch = 2;
    wait (sweeps >= 5);
    @(negedge clk); #1;
    chk(poll_err[4] == 1'b0, "R9 error flag cleared", poll_err, 0);
    // abandon a sweep part way
    repeat (37) @(negedge clk);
    en_v = 1'b0;
    repeat (40) @(negedge clk);
    q.delete(); gap_skip = 1; epoch = 3;
    en_v = 1'b1;
    wait (sweeps >= 7);
    // configuration B: all ports, Clause 22 everywhere, no idle gap
    @(negedge clk);
    en_v = 1'b0;
    repeat (20) @(negedge clk);
    q.delete(); gap_skip = 1;
    pen_v = 8'hFF; glb_v = '0; idle_v = 16'd0; epoch = 4;
    for (int p = 0; p < NP; p++) set_port(p, 31 - p, p % 4);
    en_v = 1'b1;
    wait (sweeps >= 10);
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule